// File: doc/BRIEF.md
# Timer-Driven Interrupt Request Generator

This block raises interrupt requests toward a processor interrupt controller from per-channel free-running timers. Each channel counts clock cycles up to a period set by software; each time the count wraps, a trigger event is produced. The event is shaped into a request line in one of two styles, chosen per channel. In level style the request rises and stays high until software clears it with a register write. In edge style the request is a pulse stretched to a fixed, guaranteed width, so that a controller sampling on a slower clock still captures it.

Software reaches the block through a flat register interface: a write strobe with address and data, and a combinational read port. A control word enables each channel and selects its style. One period word exists per channel. A status word reports pending level requests, sticky overrun flags for events that hit an already pending level request, and sticky missed flags for events that arrive while an edge pulse is still being stretched. Writing the status address clears bits, one bit per flag.

Top module: `irq_timer_gen`

## Requirements
- R1: After a synchronous active-high reset, every request line is low and the control, period and status words all read back as zero.
- R2: With a channel enabled and period P not zero, the channel produces one trigger event every P clock cycles. The first event makes a level request visible P cycles after the clock edge that enabled the channel.
- R3: A channel that is disabled (control bit i = 0), or whose period is zero, produces no trigger events, and its request line stays low.
- R4: In level style (control bit 2+i = 0) the request stays high once raised. Writing 1 to bit i at the status address (3) lowers it on the next clock edge.
- R5: If a clear write and a trigger event land on the same clock edge, the event wins and the level request stays high.
- R6: A level-style event that arrives while the request is still pending keeps the line high and sets sticky overrun status bit 2+i.
- R7: In edge style (control bit 2+i = 1) each accepted event drives the request high for exactly PULSE_W cycles (PULSE_W at least 2).
- R8: In edge style an event that arrives while a pulse is still high does not lengthen the pulse. It sets sticky missed status bit 4+i.
- R9: The register map is: address 0 is control (bits 0..1 enable, bits 2..3 edge style), addresses 1 and 2 are the periods of channels 0 and 1, and address 3 is status. The two channels run independently.
- R10: Writing 1 to an overrun or missed bit at the status address clears only that sticky bit and leaves the other status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all sequential logic |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (2) | Register write address |
| wr_data | input | DATA_W (16) | Register write data |
| rd_addr | input | AW (2) | Register read address |
| rd_data | output | DATA_W (16) | Combinational read data |
| irq | output | NCH (2) | Interrupt request lines, one per channel |

## Verification
The hardest situation to reach from the ports is a clear write that lands on the same edge as a trigger event. The bench counts edges from the enabling write and issues the clear so that it takes effect exactly P cycles after the previous event. A missed edge event needs events to come faster than the pulse can drain. The bench reprograms a running edge channel to a period shorter than the pulse width, then measures every complete high run at the port.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;

  typedef enum logic {
    STYLE_LEVEL = 1'b0,
    STYLE_EDGE  = 1'b1
  } irq_style_e;

  // True when a running counter has reached the last cycle of its period.
  function automatic logic period_hit(logic [31:0] cnt, logic [31:0] period);
    return (period != 32'd0) && (cnt >= period - 32'd1);
  endfunction

  // Next value of a pulse-stretch counter: load on an accepted event, else drain.
  function automatic int stretch_next(int cur, logic fire, int width);
    if (fire && cur == 0) return width;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/irq_period_timer.sv
module irq_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  import irq_gen_pkg::*;

  logic [PERIOD_W-1:0] cnt;

  assign tick = run && period_hit(32'(cnt), 32'(period));

  always_ff @(posedge clk) begin
    if (rst || !run || period == '0 || tick) cnt <= '0;
    else                                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_line_shaper.sv
module irq_line_shaper #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_mode,
  input  logic fire,
  input  logic clr_pend,
  input  logic clr_ovr,
  input  logic clr_miss,
  output logic irq,
  output logic pending,
  output logic overrun,
  output logic missed
);
  import irq_gen_pkg::*;

  localparam int SW = $clog2(PULSE_W + 1);

  logic [SW-1:0] stretch;
  logic          lvl_fire;
  logic          edge_fire;
  logic          busy;

  assign lvl_fire  = fire && (edge_mode == STYLE_LEVEL);
  assign edge_fire = fire && (edge_mode == STYLE_EDGE);
  assign busy      = (stretch != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      overrun <= 1'b0;
      missed  <= 1'b0;
      stretch <= '0;
    end else begin
      pending <= lvl_fire | (pending & ~clr_pend);
      overrun <= (lvl_fire & pending) | (overrun & ~clr_ovr);
      missed  <= (edge_fire & busy) | (missed & ~clr_miss);
      stretch <= SW'(stretch_next(int'(stretch), edge_fire, PULSE_W));
    end
  end

  assign irq = (edge_mode == STYLE_EDGE) ? busy : pending;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NCH      = 2,
  parameter int PERIOD_W = 16,
  parameter int DATA_W   = 16,
  parameter int AW       = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NCH-1:0]               st_pend,
  input  logic [NCH-1:0]               st_ovr,
  input  logic [NCH-1:0]               st_miss,
  output logic [NCH-1:0]               enable,
  output logic [NCH-1:0]               edge_mode,
  output logic [NCH-1:0][PERIOD_W-1:0] period,
  output logic [NCH-1:0]               clr_pend,
  output logic [NCH-1:0]               clr_ovr,
  output logic [NCH-1:0]               clr_miss
);
  localparam logic [AW-1:0] A_CTRL = '0;
  localparam logic [AW-1:0] A_STAT = AW'(NCH + 1);

  logic stat_wr;
  assign stat_wr  = wr_en && (wr_addr == A_STAT);
  assign clr_pend = stat_wr ? wr_data[NCH-1:0]       : '0;
  assign clr_ovr  = stat_wr ? wr_data[2*NCH-1:NCH]   : '0;
  assign clr_miss = stat_wr ? wr_data[3*NCH-1:2*NCH] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= '0;
      edge_mode <= '0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      enable    <= wr_data[NCH-1:0];
      edge_mode <= wr_data[2*NCH-1:NCH];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_per
    always_ff @(posedge clk) begin
      if (rst)                                    period[i] <= '0;
      else if (wr_en && wr_addr == AW'(i + 1))    period[i] <= wr_data[PERIOD_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[2*NCH-1:0] = {edge_mode, enable};
    end else if (rd_addr == A_STAT) begin
      rd_data[3*NCH-1:0] = {st_miss, st_ovr, st_pend};
    end else begin
      for (int i = 0; i < NCH; i++)
        if (rd_addr == AW'(i + 1)) rd_data[PERIOD_W-1:0] = period[i];
    end
  end
endmodule

// File: rtl/irq_timer_gen.sv
module irq_timer_gen #(
  parameter int NCH      = 2,
  parameter int PERIOD_W = 16,
  parameter int DATA_W   = 16,
  parameter int PULSE_W  = 4,
  localparam int AW      = $clog2(NCH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq
);
  // Named internal events, brought out for the bound checker.
  logic [NCH-1:0]               tick_w;
  logic [NCH-1:0]               enable_w;
  logic [NCH-1:0]               edge_w;
  logic [NCH-1:0][PERIOD_W-1:0] period_w;
  logic [NCH-1:0]               clr_pend_w;
  logic [NCH-1:0]               clr_ovr_w;
  logic [NCH-1:0]               clr_miss_w;
  logic [NCH-1:0]               pend_w;
  logic [NCH-1:0]               ovr_w;
  logic [NCH-1:0]               miss_w;

  irq_ctrl_regs #(.NCH(NCH), .PERIOD_W(PERIOD_W), .DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .st_pend(pend_w), .st_ovr(ovr_w), .st_miss(miss_w),
    .enable(enable_w), .edge_mode(edge_w), .period(period_w),
    .clr_pend(clr_pend_w), .clr_ovr(clr_ovr_w), .clr_miss(clr_miss_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    irq_period_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
      .clk(clk), .rst(rst), .run(enable_w[i]), .period(period_w[i]), .tick(tick_w[i])
    );
    irq_line_shaper #(.PULSE_W(PULSE_W)) u_shp (
      .clk(clk), .rst(rst), .edge_mode(edge_w[i]), .fire(tick_w[i]),
      .clr_pend(clr_pend_w[i]), .clr_ovr(clr_ovr_w[i]), .clr_miss(clr_miss_w[i]),
      .irq(irq[i]), .pending(pend_w[i]), .overrun(ovr_w[i]), .missed(miss_w[i])
    );
  end
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
  parameter int NCH      = 2,
  parameter int PERIOD_W = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NCH-1:0]               irq,
  input logic [NCH-1:0]               tick,
  input logic [NCH-1:0]               edge_mode,
  input logic [NCH-1:0]               clr_pend,
  input logic [NCH-1:0][PERIOD_W-1:0] period
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      (period[i] == '0) |-> !tick[i]);  // R3
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!edge_mode[i] && irq[i] && !clr_pend[i]) |=> (irq[i] || edge_mode[i]));  // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (!edge_mode[i] && clr_pend[i] && !tick[i]) |=> (!irq[i] || edge_mode[i]));  // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      (!edge_mode[i] && tick[i]) |=> (irq[i] || edge_mode[i]));  // R5
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[i] && $past(edge_mode[i]) && $rose(irq[i])) |=> (irq[i] || !edge_mode[i]));  // R7
  end
endmodule

bind irq_timer_gen irq_timer_chk #(.NCH(NCH), .PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .tick(tick_w), .edge_mode(edge_w),
  .clr_pend(clr_pend_w), .period(period_w)
);

// File: tb/tb_irq_timer_gen.sv
module tb_irq_timer_gen;
  localparam int CLK_NS = 10;
  localparam int PW     = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  irq;

  int total = 0;
  int bad   = 0;

  irq_timer_gen #(.NCH(2), .PERIOD_W(16), .DATA_W(16), .PULSE_W(PW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Entered at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(irq == 2'b00, "R1 irq after reset", int'(irq), 0);
    rd(2'd0, v); check(v == 16'h0, "R1 control", int'(v), 0);
    rd(2'd1, v); check(v == 16'h0, "R1 period0", int'(v), 0);
    rd(2'd3, v); check(v == 16'h0, "R1 status", int'(v), 0);
  endtask

  task automatic t_level();
    logic [15:0] v;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0001);                 // enable ch0, level style; edge e0
    wait_cyc(4); check(!irq[0], "R2 no request before period", int'(irq[0]), 0);
    wait_cyc(1); check(irq[0], "R2 request after P cycles", int'(irq[0]), 1);
    rd(2'd3, v); check(v[0], "R4 pending status", int'(v[0]), 1);
    wait_cyc(3); check(irq[0], "R4 level holds", int'(irq[0]), 1);
    rd(2'd3, v); check(!v[2], "R6 no overrun yet", int'(v[2]), 0);
    wait_cyc(3);                        // e0+11, event at e0+10 hit pending
    check(irq[0], "R6 line stays high", int'(irq[0]), 1);
    rd(2'd3, v); check(v[2], "R6 overrun sticky", int'(v[2]), 1);
    wr(2'd3, 16'h0001);                 // clear at e0+12
    check(!irq[0], "R4 clear drops request", int'(irq[0]), 0);
    wait_cyc(2); check(!irq[0], "R2 low between events", int'(irq[0]), 0);
    wait_cyc(1); check(irq[0], "R2 next event after P", int'(irq[0]), 1);
    wait_cyc(4);
    wr(2'd3, 16'h0001);                 // clear lands on event edge e0+20
    check(irq[0], "R5 event wins over clear", int'(irq[0]), 1);
    wr(2'd3, 16'h0004);                 // W1C overrun only
    rd(2'd3, v); check(v == 16'h0001, "R10 only overrun cleared", int'(v), 1);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0001);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0001);                 // enabled, period zero
    wait_cyc(30);
    check(!irq[0], "R3 zero period no request", int'(irq[0]), 0);
    rd(2'd3, v); check(v == 16'h0, "R3 status idle", int'(v), 0);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd3);                    // nonzero period, disabled
    wait_cyc(20);
    check(!irq[0], "R3 disabled no request", int'(irq[0]), 0);
    rd(2'd1, v); check(v == 16'd3, "R9 period0 readback", int'(v), 3);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h000A);                 // enable ch1, edge style; edge e0
    rd(2'd0, v); check(v == 16'h000A, "R9 control readback", int'(v), 10);
    wait_cyc(9);  check(!irq[1], "R7 low before event", int'(irq[1]), 0);
    wait_cyc(1);  check(irq[1], "R7 pulse starts", int'(irq[1]), 1);
    wait_cyc(PW - 1); check(irq[1], "R7 pulse last cycle", int'(irq[1]), 1);
    wait_cyc(1);  check(!irq[1], "R7 pulse ends after PULSE_W", int'(irq[1]), 0);
    check(!irq[0], "R9 other channel untouched", int'(irq[0]), 0);
    rd(2'd3, v); check(v == 16'h0, "R8 no miss at slow rate", int'(v), 0);
  endtask

  task automatic t_missed();
    logic [15:0] v;
    int run = 0;
    int runs = 0;
    logic armed = 1'b0;
    logic prev = 1'b0;
    wr(2'd2, 16'd2);                    // faster than pulse drains
    wait_cyc(3);
    for (int k = 0; k < 60; k++) begin
      if (!irq[1]) begin
        if (armed && prev) begin
          runs++;
          check(run == PW, "R8 pulse not extended", run, PW);
        end
        armed = 1'b1; run = 0;
      end else begin
        run++;
      end
      prev = irq[1];
      wait_cyc(1);
    end
    check(runs >= 5, "R8 pulses keep coming", runs, 5);
    rd(2'd3, v); check(v[5], "R8 missed sticky", int'(v[5]), 1);
    wr(2'd0, 16'h0000);
    wait_cyc(10);
    wr(2'd3, 16'h0020);
    rd(2'd3, v); check(v == 16'h0, "R10 missed cleared", int'(v), 0);
    check(irq == 2'b00, "R3 all quiet after disable", int'(irq), 0);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_level();
    t_idle();
    t_edge();
    t_missed();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule